// File: doc/BRIEF.md
# I2C Master SCL/SDA Timing Generator

This block produces the clock and data line timing of an I2C master from a single system clock. A byte sequencer above it asks for a START, for one data bit at a time, or for a STOP. The block answers with open-drain pull-down enables for SCL and SDA, and with one-cycle pulses that mark where each bit slot begins and ends. The output enables are active high: 1 pulls the line low and 0 releases it.

Timing is set through a small write port that only takes effect while the generator is disabled. Two pairs of SCL high and low counts exist, one for standard speed and one for fast speed, and a control field picks the pair. The SCL high and low counts are raised to a floor value when they are programmed too small. An SDA hold delay places the data change after the SCL falling edge, and an SDA setup count stretches the SCL low phase so that the data is steady long enough before SCL rises.

Register map for `cfg_addr`: 0 is the control word (bit 1 picks standard speed, bit 2 picks fast speed), 1 and 2 are the standard high and low counts, 3 and 4 are the fast high and low counts, 5 is the setup count (8 bits), and 6 is the hold register (bit 8 enables the hold, bits 7:0 hold the count). All of these registers reset to zero.

Top module: `i2c_tgen`

## Requirements
- R1: The fast high/low pair is used when control bit 2 is 1 and control bit 1 is 0. Any other control value uses the standard pair.
- R2: The effective SCL high count is the selected high register, raised to 6 if it is smaller. The effective SCL low count is the selected low register, raised to 8 if it is smaller.
- R3: When the block is idle and enabled, `start_req` drives `sda_oe` to 1 and pulses `slot_start` in the same cycle. SCL stays released for H cycles, where H is the effective high count. `scl_oe` then goes to 1 together with a `slot_end` pulse.
- R4: With hold bit 8 set, a bit slot changes `sda_oe` at cycle hold+1 after the `slot_start` cycle (that cycle counts as 0). With bit 8 clear, the change happens in the `slot_start` cycle itself.
- R5: The SCL low phase of a bit or STOP slot lasts max(effective low, d + max(setup-1, 1)) cycles, counted from the `slot_start` cycle, where d is the hold delay from R4.
- R6: `bit_req` with `bit_val` = 0 makes `sda_oe` 1, and `bit_val` = 1 makes it 0. After the low phase, SCL is released for H cycles with SDA held steady. SCL is then pulled low again with a `slot_end` pulse.
- R7: `stop_req` drives `sda_oe` to 1 at the hold point and then releases SCL for H cycles. After that, `sda_oe` returns to 0 with a `slot_end` pulse and the block is idle.
- R8: A configuration write made while `enable` is 1 has no effect.
- R9: While `enable` is 0, both enables are 0 from the next cycle on, any transfer in progress is dropped, and all requests are ignored.
- R10: `bit_req` and `stop_req` are ignored unless SCL is parked low between slots. `start_req` is ignored unless the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Generator enable; while low, configuration writes are accepted |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | REG_W | Configuration write data |
| start_req | input | 1 | Request a START condition |
| bit_req | input | 1 | Request one data bit slot |
| bit_val | input | 1 | Data bit for `bit_req` |
| stop_req | input | 1 | Request a STOP condition |
| scl_oe | output | 1 | SCL pull-down enable (1 = low) |
| sda_oe | output | 1 | SDA pull-down enable (1 = low) |
| slot_start | output | 1 | One-cycle pulse at the first cycle of a slot |
| slot_end | output | 1 | One-cycle pulse after the last cycle of a slot |

## Verification
A full frame (START, three bits whose values alternate, STOP) is run in standard mode with a hold delay shorter than the low phase. This shows that the hold point and the phase lengths come from the right registers. A second frame uses the fast pair with hold disabled and a large setup count, so the low phase is set by setup rather than by the low count. A third frame uses counts below the floors, a hold delay that stretches the low phase, and both speed bits set, so the floor and priority rules can be told apart. Further scenarios issue requests in the wrong state, attempt writes while enabled, and drop enable in the middle of a START, and confirm at the pins that nothing moves.

// File: rtl/i2c_tgen_pkg.sv
package i2c_tgen_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_PARK,
    ST_LOW,
    ST_HIGH
  } tgen_state_e;

  localparam logic [2:0] ADDR_CTRL    = 3'd0;
  localparam logic [2:0] ADDR_STD_HI  = 3'd1;
  localparam logic [2:0] ADDR_STD_LO  = 3'd2;
  localparam logic [2:0] ADDR_FAST_HI = 3'd3;
  localparam logic [2:0] ADDR_FAST_LO = 3'd4;
  localparam logic [2:0] ADDR_SETUP   = 3'd5;
  localparam logic [2:0] ADDR_HOLD    = 3'd6;

  localparam int CTRL_STD_BIT  = 1;
  localparam int CTRL_FAST_BIT = 2;

endpackage

// File: rtl/i2c_tgen_cfg.sv
module i2c_tgen_cfg
  import i2c_tgen_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int SU_W   = 8,
  parameter int HD_W   = 8,
  parameter int HI_MIN = 6,
  parameter int LO_MIN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] hi_eff,
  output logic [REG_W-1:0] low_eff,
  output logic [HD_W:0]    hold_dly
);

  localparam logic [REG_W-1:0] HI_MIN_V = REG_W'(HI_MIN);
  localparam logic [REG_W-1:0] LO_MIN_V = REG_W'(LO_MIN);

  logic             std_sel_q, fast_sel_q;
  logic [REG_W-1:0] std_hi_q, std_lo_q, fast_hi_q, fast_lo_q;
  logic [SU_W-1:0]  setup_q;
  logic [HD_W:0]    hold_q;

  // Register writes, gated off while the generator runs (R8)
  always_ff @(posedge clk) begin
    if (rst) begin
      std_sel_q  <= 1'b0;
      fast_sel_q <= 1'b0;
      std_hi_q   <= '0;
      std_lo_q   <= '0;
      fast_hi_q  <= '0;
      fast_lo_q  <= '0;
      setup_q    <= '0;
      hold_q     <= '0;
    end else if (cfg_we && !enable) begin
      case (cfg_addr)
        ADDR_CTRL: begin
          std_sel_q  <= cfg_wdata[CTRL_STD_BIT];
          fast_sel_q <= cfg_wdata[CTRL_FAST_BIT];
        end
        ADDR_STD_HI:  std_hi_q  <= cfg_wdata;
        ADDR_STD_LO:  std_lo_q  <= cfg_wdata;
        ADDR_FAST_HI: fast_hi_q <= cfg_wdata;
        ADDR_FAST_LO: fast_lo_q <= cfg_wdata;
        ADDR_SETUP:   setup_q   <= cfg_wdata[SU_W-1:0];
        ADDR_HOLD:    hold_q    <= cfg_wdata[HD_W:0];
        default: ;
      endcase
    end
  end

  logic             use_fast;
  logic [REG_W-1:0] sel_hi, sel_lo, hi_floor, lo_floor, need_lo, lo_final;
  logic [HD_W:0]    hd_c;
  logic [SU_W-1:0]  su_c;

  always_comb begin
    use_fast = fast_sel_q && !std_sel_q;                   // R1
    sel_hi   = use_fast ? fast_hi_q : std_hi_q;
    sel_lo   = use_fast ? fast_lo_q : std_lo_q;
    hi_floor = (sel_hi < HI_MIN_V) ? HI_MIN_V : sel_hi;    // R2
    lo_floor = (sel_lo < LO_MIN_V) ? LO_MIN_V : sel_lo;
    hd_c     = hold_q[HD_W] ? ({1'b0, hold_q[HD_W-1:0]} + (HD_W+1)'(1))
                            : '0;                          // R4
    su_c     = (setup_q < SU_W'(2)) ? SU_W'(1) : (setup_q - SU_W'(1));
    need_lo  = REG_W'(hd_c) + REG_W'(su_c);                // R5
    lo_final = (need_lo > lo_floor) ? need_lo : lo_floor;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_eff   <= HI_MIN_V;
      low_eff  <= LO_MIN_V;
      hold_dly <= '0;
    end else begin
      hi_eff   <= hi_floor;
      low_eff  <= lo_final;
      hold_dly <= hd_c;
    end
  end

  // R8: a write during operation leaves every register untouched
  a_r8_frozen_while_enabled: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && enable) |=> ($stable(std_hi_q) && $stable(std_lo_q) &&
                            $stable(fast_hi_q) && $stable(fast_lo_q) &&
                            $stable(setup_q) && $stable(hold_q) &&
                            $stable(std_sel_q) && $stable(fast_sel_q)));

  // R2: the effective counts never drop under their floors
  a_r2_floor_kept: assert property (@(posedge clk) disable iff (rst)
    (hi_eff >= HI_MIN_V) && (low_eff >= LO_MIN_V));

  // R5: the low phase always leaves room for the data change
  a_r5_low_covers_hold: assert property (@(posedge clk) disable iff (rst)
    low_eff > REG_W'(hold_dly));

endmodule

// File: rtl/i2c_tgen_fsm.sv
module i2c_tgen_fsm
  import i2c_tgen_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int HD_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             start_req,
  input  logic             bit_req,
  input  logic             bit_val,
  input  logic             stop_req,
  input  logic [REG_W-1:0] hi_eff,
  input  logic [REG_W-1:0] low_eff,
  input  logic [HD_W:0]    hold_dly,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             slot_start,
  output logic             slot_end
);

  localparam logic [REG_W-1:0] ONE = REG_W'(1);

  tgen_state_e      state;
  logic [REG_W-1:0] cnt;
  logic             drv_val;
  logic             stop_q;

  logic [REG_W-1:0] hi_m1, lo_m1, hold_ext;
  logic             hold_hit, park_go, park_val;

  always_comb begin
    hi_m1    = hi_eff - ONE;
    lo_m1    = low_eff - ONE;
    hold_ext = REG_W'(hold_dly);
    hold_hit = (hold_ext != '0) && (cnt == hold_ext - ONE);
    park_go  = bit_req || stop_req;
    park_val = bit_req ? ~bit_val : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      scl_oe     <= 1'b0;
      sda_oe     <= 1'b0;
      slot_start <= 1'b0;
      slot_end   <= 1'b0;
      drv_val    <= 1'b0;
      stop_q     <= 1'b0;
    end else begin
      slot_start <= 1'b0;
      slot_end   <= 1'b0;
      if (!enable) begin                                   // R9
        state  <= ST_IDLE;
        cnt    <= '0;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
        stop_q <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: if (start_req) begin                    // R3
            state      <= ST_START;
            cnt        <= '0;
            sda_oe     <= 1'b1;
            slot_start <= 1'b1;
          end
          ST_START: begin
            if (cnt == hi_m1) begin
              state    <= ST_PARK;
              scl_oe   <= 1'b1;
              slot_end <= 1'b1;
              cnt      <= '0;
            end else begin
              cnt <= cnt + ONE;
            end
          end
          ST_PARK: if (park_go) begin                      // R10: only here
            state      <= ST_LOW;
            cnt        <= '0;
            slot_start <= 1'b1;
            stop_q     <= !bit_req;
            drv_val    <= park_val;
            if (hold_ext == '0) sda_oe <= park_val;        // R4 no hold
          end
          ST_LOW: begin
            if (hold_hit) sda_oe <= drv_val;               // R4 hold point
            if (cnt == lo_m1) begin                        // R5
              state  <= ST_HIGH;
              scl_oe <= 1'b0;
              cnt    <= '0;
            end else begin
              cnt <= cnt + ONE;
            end
          end
          ST_HIGH: begin
            if (cnt == hi_m1) begin
              cnt      <= '0;
              slot_end <= 1'b1;
              if (stop_q) begin                            // R7
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
              end else begin                               // R6
                state  <= ST_PARK;
                scl_oe <= 1'b1;
              end
            end else begin
              cnt <= cnt + ONE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: during START, SDA is low while SCL is released
  a_r3_start_shape: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START) |-> (sda_oe && !scl_oe));

  // R4: SDA keeps its old value until the hold point
  a_r4_hold_window: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOW && cnt != '0 && cnt < hold_ext) |-> $stable(sda_oe));

  // R6: SDA does not move while SCL is high within a slot
  a_r6_sda_steady_high: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HIGH && $past(state) == ST_HIGH) |-> $stable(sda_oe));

  // R7: SDA is released with SCL high only when a STOP completes
  a_r7_release_at_stop: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_oe) && !scl_oe && $past(enable)) |-> ($past(state) == ST_HIGH && $past(stop_q)));

  // R9: disabling releases both lines on the next cycle
  a_r9_disable_release: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!scl_oe && !sda_oe && state == ST_IDLE));

  // R6: slot markers never coincide
  a_r6_marker_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({slot_start, slot_end}));

endmodule

// File: rtl/i2c_tgen.sv
module i2c_tgen
  import i2c_tgen_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int SU_W   = 8,
  parameter int HD_W   = 8,
  parameter int HI_MIN = 6,
  parameter int LO_MIN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             start_req,
  input  logic             bit_req,
  input  logic             bit_val,
  input  logic             stop_req,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             slot_start,
  output logic             slot_end
);

  logic [REG_W-1:0] hi_eff, low_eff;
  logic [HD_W:0]    hold_dly;

  i2c_tgen_cfg #(
    .REG_W (REG_W),
    .SU_W  (SU_W),
    .HD_W  (HD_W),
    .HI_MIN(HI_MIN),
    .LO_MIN(LO_MIN)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .hi_eff   (hi_eff),
    .low_eff  (low_eff),
    .hold_dly (hold_dly)
  );

  i2c_tgen_fsm #(
    .REG_W(REG_W),
    .HD_W (HD_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .start_req (start_req),
    .bit_req   (bit_req),
    .bit_val   (bit_val),
    .stop_req  (stop_req),
    .hi_eff    (hi_eff),
    .low_eff   (low_eff),
    .hold_dly  (hold_dly),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .slot_start(slot_start),
    .slot_end  (slot_end)
  );

endmodule

// File: tb/i2c_tgen_bench.sv
`timescale 1ns/1ps
module i2c_tgen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        start_req = 1'b0, bit_req = 1'b0, bit_val = 1'b0, stop_req = 1'b0;
  logic        scl_oe, sda_oe, slot_start, slot_end;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_tgen u_i2c_tgen (
    .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start_req(start_req), .bit_req(bit_req), .bit_val(bit_val),
    .stop_req(stop_req), .scl_oe(scl_oe), .sda_oe(sda_oe), .slot_start(slot_start),
    .slot_end(slot_end)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // START: SDA low at once, SCL released for h cycles
  task automatic run_start(input int h, input string req);
    int high = 0;
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    check(slot_start && sda_oe && !scl_oe, req, "start first cycle",
          {slot_start, sda_oe, scl_oe}, 6);
    while (scl_oe == 1'b0 && high < 5000) begin high++; @(negedge clk); end
    check(high == h, req, "start SCL high length", high, h);
    check(slot_end && scl_oe && sda_oe, req, "start end", {slot_end, scl_oe, sda_oe}, 7);
  endtask

  // Bit or STOP slot: low length, hold index, high length
  task automatic run_slot(input bit is_stop, input bit val, input int l, input int idx,
                          input int h, input string req);
    int low = 0;
    int high = 0;
    int sidx = -1;
    logic exp_sda;
    exp_sda = is_stop ? 1'b1 : ~val;
    @(negedge clk);
    if (is_stop) stop_req = 1'b1; else begin bit_req = 1'b1; bit_val = val; end
    @(negedge clk);
    stop_req = 1'b0; bit_req = 1'b0;
    check(slot_start == 1'b1, req, "slot_start pulse", slot_start, 1);
    while (scl_oe == 1'b1 && low < 5000) begin
      if (sidx < 0 && sda_oe == exp_sda) sidx = low;
      low++;
      @(negedge clk);
    end
    check(low == l, req, "SCL low length", low, l);
    check(sidx == idx, req, "SDA change cycle", sidx, idx);
    if (!is_stop) begin
      while (scl_oe == 1'b0 && high < 5000) begin high++; @(negedge clk); end
      check(high == h, req, "SCL high length", high, h);
      check(slot_end && scl_oe && sda_oe == exp_sda, req, "bit end",
            {slot_end, scl_oe, sda_oe}, {1'b1, 1'b1, exp_sda});
    end else begin
      while (scl_oe == 1'b0 && sda_oe == 1'b1 && high < 5000) begin high++; @(negedge clk); end
      check(high == h, req, "stop SCL high length", high, h);
      check(slot_end && !sda_oe && !scl_oe, req, "stop release",
            {slot_end, sda_oe, scl_oe}, 4);
    end
  endtask

  task automatic watch_quiet(input int n, input logic exp_scl, input logic exp_sda,
                             input string req);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (slot_start || scl_oe != exp_scl || sda_oe != exp_sda) ok = 1'b0;
    end
    check(ok, req, "no reaction to request", {slot_start, scl_oe, sda_oe},
          {1'b0, exp_scl, exp_sda});
  endtask

  task automatic t_reset();
    check(!scl_oe && !sda_oe && !slot_start && !slot_end, "R9", "reset state",
          {scl_oe, sda_oe, slot_start, slot_end}, 0);
  endtask

  // Standard mode frame with hold 2 -> delay 3, setup 3
  task automatic t_std_frame();
    wr(3'd0, 16'h0002); wr(3'd1, 16'd10); wr(3'd2, 16'd12);
    wr(3'd3, 16'd3);    wr(3'd4, 16'd20); wr(3'd5, 16'd3); wr(3'd6, 16'h0102);
    settle(); enable = 1'b1; settle();
    run_start(10, "R3");
    run_slot(1'b0, 1'b1, 12, 3, 10, "R4");
    run_slot(1'b0, 1'b0, 12, 3, 10, "R6");
    run_slot(1'b0, 1'b1, 12, 3, 10, "R6");
    run_slot(1'b1, 1'b0, 12, 3, 10, "R7");
  endtask

  // Fast pair, hold disabled, large setup stretches low phase
  task automatic t_fast_setup();
    enable = 1'b0; settle();
    wr(3'd0, 16'h0004); wr(3'd5, 16'd40); wr(3'd6, 16'h00FF);
    settle(); enable = 1'b1; settle();
    run_start(6, "R1");
    run_slot(1'b0, 1'b1, 39, 0, 6, "R5");
    run_slot(1'b1, 1'b0, 39, 0, 6, "R5");
  endtask

  // Both speed bits -> standard; counts under floors; hold stretches low
  task automatic t_floors();
    enable = 1'b0; settle();
    wr(3'd0, 16'h0006); wr(3'd1, 16'd4); wr(3'd2, 16'd2);
    wr(3'd5, 16'd1);    wr(3'd6, 16'h0109);
    settle(); enable = 1'b1; settle();
    run_start(6, "R2");
    run_slot(1'b0, 1'b1, 11, 10, 6, "R2");
    run_slot(1'b1, 1'b0, 11, 10, 6, "R1");
  endtask

  // Writes while enabled are dropped; misplaced requests ignored
  task automatic t_ignored();
    wr(3'd1, 16'd30);
    wr(3'd6, 16'h0000);
    settle();
    @(negedge clk) bit_req = 1'b1; bit_val = 1'b0;
    @(negedge clk) bit_req = 1'b0;
    watch_quiet(5, 1'b0, 1'b0, "R10");
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
    watch_quiet(5, 1'b0, 1'b0, "R10");
    run_start(6, "R8");
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    watch_quiet(5, 1'b1, 1'b1, "R10");
    run_slot(1'b0, 1'b1, 11, 10, 6, "R8");
    run_slot(1'b1, 1'b0, 11, 10, 6, "R8");
  endtask

  // Drop enable mid-START; requests while disabled are ignored
  task automatic t_disable();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    repeat (2) @(negedge clk);
    check(sda_oe && !scl_oe, "R9", "START in progress", {sda_oe, scl_oe}, 2);
    enable = 1'b0;
    @(negedge clk);
    check(!sda_oe && !scl_oe, "R9", "lines released after disable", {sda_oe, scl_oe}, 0);
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    watch_quiet(5, 1'b0, 1'b0, "R9");
    enable = 1'b1; settle();
    run_start(6, "R9");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    settle();
    t_std_frame();
    t_fast_setup();
    t_floors();
    t_ignored();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule